// File: doc/BRIEF.md
# Transparent Serial Transmit Channel

This block serialises parallel characters onto a single data line with no framing. The character source is a holding interface: the block takes a character, together with a flag that marks the final character of a buffer, only in a cycle where the bit clock enable pulses and the shifter needs new data. Character length (1 to 16 bits) and shift order (least or most significant bit first) are set by control inputs. The line rests high whenever nothing is being sent.

Buffer boundaries are tracked through the final-character flag. When the final character of a buffer has shifted out completely, the block closes the buffer with a clean status pulse. If a character ends inside a buffer and no successor is offered, the channel starves. It closes the buffer with the underrun flag, records a transmit-error event and halts. It then accepts nothing until a restart command arrives. Running dry after a buffer has closed is plain idle. Two sticky event bits (buffer-sent, transmit-error) are cleared by writing ones, and a two-bit mask gates them onto the interrupt line.

Top module: `ser_tx_chan`

## Requirements
- R1: After reset, txd is 1, ev and im are 0, irq is 0 and hold_ready is 0.
- R2: hold_ready is high only in a cycle with tx_en and bit_tick both high while the channel is idle or has finished its current character. A character taken in that cycle drives its first bit on txd from the next clock. Each later bit_tick advances one bit. A character taken right after the previous one follows it with no gap.
- R3: With msb_first 0 a character goes out least significant bit first. With msb_first 1 it starts at bit len_m1 and ends at bit 0.
- R4: A character is len_m1+1 bits long (len_m1 from 0 to 15). Data bits above len_m1 are never sent.
- R5: When the last bit period of a character taken with hold_last 1 ends (the next bit_tick), buf_done pulses for one cycle with buf_unrun 0, and ev[0] (buffer sent) is set.
- R6: When a character taken with hold_last 0 ends and hold_valid is low on that bit_tick, the channel reports underrun. buf_done and buf_unrun pulse together, ev[1] (transmit error) is set, and txd goes high.
- R7: After an underrun, hold_ready stays 0 and txd stays 1 until a restart pulse. After the restart the channel is idle and sends the next characters offered as a new buffer.
- R8: Having no character to send after a buffer has closed is idle. It raises neither buf_unrun nor ev[1].
- R9: While tx_en is 0, hold_ready is 0 and txd is 1 from the next clock. A character in flight is dropped without any status.
- R10: Event bits stay set until ev_clr_we is pulsed with a 1 in the matching ev_clr position. If a bit is set and cleared in the same cycle, the set wins.
- R11: im follows im_wdata on each im_we pulse. irq is high exactly when some bit is set in both ev and im.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | Bit clock enable, one pulse per bit period |
| tx_en | input | 1 | Transmit enable |
| msb_first | input | 1 | 1 = most significant bit first |
| len_m1 | input | 4 | Character length minus one |
| hold_valid | input | 1 | A character is offered |
| hold_data | input | 16 | Offered character |
| hold_last | input | 1 | Offered character ends its buffer |
| hold_ready | output | 1 | Character taken this cycle when hold_valid is high |
| restart | input | 1 | Restart-transmit command pulse |
| ev_clr_we | input | 1 | Event clear strobe |
| ev_clr | input | 2 | Ones clear the matching event bits |
| im_we | input | 1 | Mask write strobe |
| im_wdata | input | 2 | New mask value |
| ev | output | 2 | Events: bit 0 buffer sent, bit 1 transmit error |
| im | output | 2 | Interrupt mask |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial data, idle high |
| buf_done | output | 1 | Buffer closed pulse |
| buf_unrun | output | 1 | Closed buffer ended in underrun |

## Verification
Some properties are checked on every cycle. An underrun pulse always follows a starved handshake and comes with a close pulse and the error event. A halted channel never takes data and holds the line high. A disabled channel takes nothing and idles the line. The error event holds until it is explicitly cleared. Other behaviour only the bench scenarios can show: the bit sequence itself under each length and order, the difference between a starved buffer and an idle gap, and the fact that restart resumes with the next buffer. A reference model that compares every output on every clock covers these.

// File: rtl/ser_tx_chan.sv
module ser_tx_chan #(
  parameter int MAXW = 16,
  localparam int LW = $clog2(MAXW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            tx_en,
  input  logic            msb_first,
  input  logic [LW-1:0]   len_m1,
  input  logic            hold_valid,
  input  logic [MAXW-1:0] hold_data,
  input  logic            hold_last,
  output logic            hold_ready,
  input  logic            restart,
  input  logic            ev_clr_we,
  input  logic [1:0]      ev_clr,
  input  logic            im_we,
  input  logic [1:0]      im_wdata,
  output logic [1:0]      ev,
  output logic [1:0]      im,
  output logic            irq,
  output logic            txd,
  output logic            buf_done,
  output logic            buf_unrun
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_HALT} st_t;

  st_t             st;
  logic [MAXW-1:0] sh;
  logic [LW-1:0]   left;
  logic            cur_last, txd_q, done_q, un_q;
  logic [1:0]      ev_q, im_q, ev_set;
  logic            need, take, end_char, buf_ok, starve;
  logic [MAXW-1:0] ord;

  function automatic logic [MAXW-1:0] flip(input logic [MAXW-1:0] d, input logic [LW-1:0] n);
    logic [LW-1:0] k;
    flip = '0;
    for (int i = 0; i < MAXW; i++) begin
      k = n - LW'(i);
      if (i <= int'(n)) flip[i] = d[k];
    end
  endfunction

  assign ord        = msb_first ? flip(hold_data, len_m1) : hold_data;
  assign need       = (st == S_IDLE) || (st == S_SEND && left == '0);
  assign hold_ready = tx_en && bit_tick && need;
  assign take       = hold_ready && hold_valid;
  assign end_char   = tx_en && bit_tick && st == S_SEND && left == '0;
  assign buf_ok     = end_char && cur_last;
  assign starve     = end_char && !cur_last && !hold_valid;
  assign ev_set     = {starve, buf_ok};

  assign txd       = txd_q;
  assign buf_done  = done_q;
  assign buf_unrun = un_q;
  assign ev        = ev_q;
  assign im        = im_q;
  assign irq       = |(ev_q & im_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      left     <= '0;
      cur_last <= 1'b0;
      txd_q    <= 1'b1;
      done_q   <= 1'b0;
      un_q     <= 1'b0;
      ev_q     <= '0;
      im_q     <= '0;
    end else begin
      done_q <= 1'b0;
      un_q   <= 1'b0;
      if (im_we) im_q <= im_wdata;
      ev_q <= (ev_q & ~(ev_clr_we ? ev_clr : 2'b00)) | ev_set;
      if (st == S_HALT) begin
        if (restart) st <= S_IDLE;
      end else if (!tx_en) begin
        st    <= S_IDLE;
        txd_q <= 1'b1;
      end else if (bit_tick) begin
        if (st == S_SEND && left != '0) begin
          txd_q <= sh[0];
          sh    <= sh >> 1;
          left  <= left - 1'b1;
        end else begin
          if (buf_ok) done_q <= 1'b1;
          if (take) begin
            txd_q    <= ord[0];
            sh       <= ord >> 1;
            left     <= len_m1;
            cur_last <= hold_last;
            st       <= S_SEND;
          end else if (starve) begin
            done_q <= 1'b1;
            un_q   <= 1'b1;
            txd_q  <= 1'b1;
            st     <= S_HALT;
          end else begin
            txd_q <= 1'b1;
            st    <= S_IDLE;
          end
        end
      end
    end
  end

endmodule

module ser_tx_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       tx_en,
  input logic       hold_valid,
  input logic       hold_ready,
  input logic       restart,
  input logic       txd,
  input logic       buf_done,
  input logic       buf_unrun,
  input logic       ev_clr_we,
  input logic [1:0] ev_clr,
  input logic [1:0] ev
);

  logic halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         halted <= 1'b0;
    else if (restart)   halted <= 1'b0;
    else if (buf_unrun) halted <= 1'b1;
  end

  AST_UN_AFTER_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unrun |-> $past(hold_ready && !hold_valid)); // R6
  AST_UN_CLOSES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unrun |-> buf_done); // R6
  AST_UN_RAISES_TXE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unrun |-> ev[1]); // R6
  AST_CLOSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> $past(bit_tick)); // R5
  AST_HALT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!hold_ready && txd)); // R7
  AST_OFF_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !hold_ready); // R9
  AST_OFF_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd); // R9
  AST_TXE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev[1]) && !$past(ev_clr_we && ev_clr[1])) |-> ev[1]); // R10

endmodule

bind ser_tx_chan ser_tx_chan_chk u_chk (.*);

// File: tb/test_ser_tx_chan.sv
module test_ser_tx_chan;
  localparam int W  = 16;
  localparam int LW = 4;

  logic clk = 0, rst_n = 0, bit_tick = 0, tx_en = 0, msb_first = 0;
  logic [LW-1:0] len_m1 = '0;
  logic hold_valid = 0, hold_last = 0, hold_ready;
  logic [W-1:0] hold_data = '0;
  logic restart = 0, ev_clr_we = 0, im_we = 0;
  logic [1:0] ev_clr = '0, im_wdata = '0, ev, im;
  logic irq, txd, buf_done, buf_unrun;

  always #4 clk = ~clk;

  ser_tx_chan #(.MAXW(W)) i_ser_tx_chan (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .msb_first(msb_first),
    .len_m1(len_m1), .hold_valid(hold_valid), .hold_data(hold_data), .hold_last(hold_last),
    .hold_ready(hold_ready), .restart(restart), .ev_clr_we(ev_clr_we), .ev_clr(ev_clr),
    .im_we(im_we), .im_wdata(im_wdata), .ev(ev), .im(im), .irq(irq), .txd(txd),
    .buf_done(buf_done), .buf_unrun(buf_unrun));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // character source and bit clock
  logic [W-1:0] q_d[$];
  logic         q_l[$];
  logic feed_en = 1, took = 0, tick_en = 0;
  int   tdiv = 0;

  always @(posedge clk) took <= hold_ready && hold_valid;

  always @(negedge clk) begin
    if (took && q_d.size() > 0) begin
      void'(q_d.pop_front());
      void'(q_l.pop_front());
    end
    hold_valid = feed_en && q_d.size() > 0;
    hold_data  = hold_valid ? q_d[0] : '0;
    hold_last  = hold_valid ? q_l[0] : 1'b0;
    tdiv       = (tdiv == 2) ? 0 : tdiv + 1;
    bit_tick   = tick_en && tdiv == 0;
  end

  // reference model
  int   m_st;
  bit   m_q[$];
  bit   m_last, m_txd, m_done, m_un;
  bit [1:0] m_ev, m_im;

  always @(posedge clk or negedge rst_n) begin : mdl
    bit [1:0] set;
    if (!rst_n) begin
      m_st = 0; m_q.delete(); m_last = 0; m_txd = 1; m_done = 0; m_un = 0; m_ev = 0; m_im = 0;
    end else begin
      set = 0; m_done = 0; m_un = 0;
      if (m_st == 2) begin
        if (restart) m_st = 0;
      end else if (!tx_en) begin
        m_st = 0; m_q.delete(); m_txd = 1;
      end else if (bit_tick) begin
        if (m_st == 1 && m_q.size() > 0) m_txd = m_q.pop_front();
        else begin
          if (m_st == 1 && m_last) begin m_done = 1; set[0] = 1; end
          if (hold_valid) begin
            for (int i = 0; i <= int'(len_m1); i++)
              m_q.push_back(hold_data[msb_first ? int'(len_m1) - i : i]);
            m_txd = m_q.pop_front(); m_last = hold_last; m_st = 1;
          end else if (m_st == 1 && !m_last) begin
            m_done = 1; m_un = 1; set[1] = 1; m_st = 2; m_txd = 1;
          end else begin
            m_st = 0; m_txd = 1;
          end
        end
      end
      if (ev_clr_we) m_ev = m_ev & ~ev_clr;
      m_ev = m_ev | set;
      if (im_we) m_im = im_wdata;
    end
  end

  always @(negedge clk) begin
    bit exp_rdy;
    if (rst_n) begin
      #2;
      exp_rdy = tx_en && bit_tick && (m_st == 0 || (m_st == 1 && m_q.size() == 0));
      chk(txd == m_txd, "R2 R3 R4 txd", txd, m_txd);
      chk(hold_ready == exp_rdy, "R2 R7 R9 hold_ready", hold_ready, exp_rdy);
      chk(buf_done == m_done, "R5 buf_done", buf_done, m_done);
      chk(buf_unrun == m_un, "R6 R8 buf_unrun", buf_unrun, m_un);
      chk(ev == m_ev, "R5 R6 R10 ev", ev, m_ev);
      chk(im == m_im, "R11 im", im, m_im);
      chk(irq == |(m_ev & m_im), "R11 irq", irq, |(m_ev & m_im));
    end
  end

  task automatic push(input logic [W-1:0] d, input logic l);
    q_d.push_back(d); q_l.push_back(l);
  endtask

  task automatic drain();
    while (q_d.size() != 0) @(negedge clk);
    repeat (70) @(negedge clk);
  endtask

  task automatic write_im(input logic [1:0] v);
    @(negedge clk); im_we = 1; im_wdata = v;
    @(negedge clk); im_we = 0;
  endtask

  task automatic clear_ev(input logic [1:0] v);
    @(negedge clk); ev_clr_we = 1; ev_clr = v;
    @(negedge clk); ev_clr_we = 0; ev_clr = 0;
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    #3;
    chk(txd == 1, "R1 txd", txd, 1);
    chk(ev == 0, "R1 ev", ev, 0);
    chk(im == 0, "R1 im", im, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(hold_ready == 0, "R1 hold_ready", hold_ready, 0);
    @(negedge clk); rst_n = 1; tick_en = 1; tx_en = 1;
    write_im(2'b11);

    // LSB first, 8-bit, three-character buffer
    len_m1 = 4'd7; msb_first = 0;
    push(16'h00A5, 0); push(16'hFF3C, 0); push(16'h000F, 1);
    drain();
    #3 chk(ev == 2'b01, "R5 buffer sent event", ev, 2'b01);
    chk(irq == 1, "R11 irq with mask", irq, 1);
    clear_ev(2'b01);
    #3 chk(ev == 2'b00, "R10 write-one clear", ev, 0);

    // MSB first, 5-bit; then 16-bit; then 1-bit
    len_m1 = 4'd4; msb_first = 1;
    push(16'h0013, 0); push(16'hFFE6, 1);
    drain();
    len_m1 = 4'd15;
    push(16'hC3A1, 0); push(16'h5A0F, 1);
    drain();
    len_m1 = 4'd0; msb_first = 0;
    push(16'h0001, 0); push(16'h0000, 0); push(16'h0001, 0); push(16'h0001, 1);
    drain();
    #3 chk(ev == 2'b01, "R3 R4 buffers closed cleanly", ev, 2'b01);
    clear_ev(2'b11);

    // idle gap between buffers is not an error
    len_m1 = 4'd3;
    push(16'h0009, 0); push(16'h0006, 1);
    drain();
    repeat (30) @(negedge clk);
    push(16'h000C, 1);
    drain();
    #3 chk(ev[1] == 0, "R8 no error in gap", ev[1], 0);
    clear_ev(2'b11);

    // underrun inside a buffer, then halt and restart
    len_m1 = 4'd7; msb_first = 1;
    push(16'h0081, 0); push(16'h007E, 0);
    drain();
    #3 chk(ev[1] == 1, "R6 transmit error event", ev[1], 1);
    chk(txd == 1, "R6 line high after underrun", txd, 1);
    push(16'h0055, 0); push(16'h00AA, 1);
    repeat (40) @(negedge clk);
    #3 chk(q_d.size() == 2, "R7 nothing taken while halted", q_d.size(), 2);
    write_im(2'b01);
    #3 chk(irq == 0, "R11 masked error gives no irq", irq, 0);
    clear_ev(2'b11);
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    drain();
    #3 chk(ev == 2'b01, "R7 next buffer sent after restart", ev, 2'b01);
    clear_ev(2'b01);

    // enable dropped mid-character
    push(16'h00F0, 0); push(16'h0033, 0); push(16'h00CC, 0); push(16'h0099, 1);
    repeat (10) @(negedge clk);
    tx_en = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      #3 chk(txd == 1 && hold_ready == 0, "R9 disabled line idle", txd, 1);
      @(negedge clk);
    end
    tx_en = 1;
    drain();
    #3 chk(ev == 2'b01, "R9 resumes after enable", ev, 2'b01);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R2 actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule